// File: doc/BRIEF.md
# Hardware Page-Table Walker

This block turns a virtual address into a physical address for one instruction fetch, data load or data store at a time. It takes the root page number, a translation mode, the current privilege and four status controls: a modify-privilege enable, the previous privilege it selects, a flag that lets supervisor code use user pages, and a flag that makes executable pages readable. From these it reads page-table entries through a single memory port and applies the leaf permission rules. When the accessed or dirty flag of a leaf has to change, it writes the entry back. The result is either a physical address with read, write and execute permissions, or a fault.

A request is accepted in the idle state. Each level of the walk issues one read, and only one memory transaction is outstanding at any time. The translation mode is the only input that selects the table geometry, and a single configuration can walk every supported geometry.

Top module: `ptw_walker`

## Requirements
- R1: Mode codes are 0 bare; 1 two levels with 10-bit indices and 4-byte entries; 2, 3 and 4 give three, four and five levels with 9-bit indices and 8-byte entries. An entry address is the table base plus index times entry size. The index is taken from the virtual address at bit 12 plus the current shift. The shift starts at (levels−1)×index width and drops by the index width at each level. A 4-byte entry is read from the low 32 bits of the read data (the bench places it in half addr[2] of a 64-bit word) and written from the low 32 bits.
- R2: With bare mode, or with an effective privilege of machine (code 3), the request completes with no memory access. The result carries paddr equal to the low PA_W bits of vaddr and all three permissions set, and res_valid rises two cycles after the accepting edge.
- R3: For a load or store (access codes 1 and 2; fetch is 0) issued at machine privilege with cfg_mprv set, the effective privilege is cfg_mpp. A fetch always uses cfg_priv. Privilege codes are U=0, S=1, M=3.
- R4: All virtual address bits from (12 + levels×index width − 1) upward must be equal. If they are not, or if the mode code is 5 to 7, the request faults without any memory access.
- R5: Entry bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7, with the page number from bit 10 (22 bits for 4-byte entries, PA_W−12 bits for 8-byte entries). An entry with V clear faults. An entry with V set and R, W and X all clear points to the next table (base = page number × 4096), and it faults at the last level.
- R6: A leaf with W set and R clear (W-only or W+X) faults.
- R7: A leaf with U set faults when the effective privilege is not user, unless cfg_sum is set and the access is not a fetch. A leaf with U clear faults unless the effective privilege is supervisor.
- R8: A leaf whose page number has nonzero bits below the current shift faults. Otherwise the physical page number is the leaf page number OR the virtual page number bits below the shift.
- R9: A load needs R, or X with cfg_mxr set. A store needs W. A fetch needs X.
- R10: A successful leaf with A clear, or a store to a leaf with D clear, is written back with A set and, for stores, D set. No write happens when nothing changes.
- R11: Before the write-back the entry is read again. If it differs from the first read, the walk restarts from the root.
- R12: On success, res_r = R | (X & cfg_mxr), res_x = X, and res_w = W & (store | D). A fault returns paddr 0 and no permissions.
- R13: A memory request holds its address, write flag and data until it is accepted. The next request is issued only after the response. res_valid is a one-cycle pulse, and after reset only req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | VA_W | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| cfg_mode | input | 3 | Translation mode code |
| cfg_root_ppn | input | PA_W-12 | Root table page number |
| cfg_priv | input | 2 | Current privilege |
| cfg_mprv | input | 1 | Modify-privilege enable |
| cfg_mpp | input | 2 | Privilege used when cfg_mprv applies |
| cfg_sum | input | 1 | Supervisor may use user pages |
| cfg_mxr | input | 1 | Executable pages readable |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_req_we | output | 1 | Write request |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_rdata | input | DATA_W | Read data |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Translation failed |
| res_paddr | output | PA_W | Physical address |
| res_r | output | 1 | Read permission |
| res_w | output | 1 | Write permission |
| res_x | output | 1 | Execute permission |

## Verification
A bypassed or rejected request is due exactly two cycles after the accepting edge. With a memory that is always ready and answers one cycle after acceptance, a walk costs three cycles per level plus two, and a write-back adds four more. The bench counts negative clock edges from the cycle in which it drives the request, checks these exact counts on directed cases, and otherwise samples the result on the first negative edge at which res_valid is seen. The memory model also counts reads and writes, so the restart and write-back paths are confirmed by their transaction counts and by the stored entry.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } acc_e;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam int BIT_V = 0;
   localparam int BIT_R = 1;
   localparam int BIT_W = 2;
   localparam int BIT_X = 3;
   localparam int BIT_U = 4;
   localparam int BIT_A = 6;
   localparam int BIT_D = 7;
   localparam int PPN_LSB = 10;
   localparam int PG_SHIFT = 12;

   typedef struct packed {
      logic [2:0] levels;
      logic [3:0] idx_bits;
      logic       esz4;
      logic       bare;
      logic       rsvd;
   } geom_t;

   function automatic geom_t mode_geom(input logic [2:0] m);
      geom_t g;
      g = '{levels: 3'd1, idx_bits: 4'd9, esz4: 1'b0, bare: 1'b0, rsvd: 1'b0};
      case (m)
         3'd0: g.bare = 1'b1;
         3'd1: begin g.levels = 3'd2; g.idx_bits = 4'd10; g.esz4 = 1'b1; end
         3'd2: g.levels = 3'd3;
         3'd3: g.levels = 3'd4;
         3'd4: g.levels = 3'd5;
         default: g.rsvd = 1'b1;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/ptw_xlate_ctl.sv
module ptw_xlate_ctl
   import ptw_pkg::*;
#(
   parameter int VA_W = 64
) (
   input  logic [VA_W-1:0] vaddr,
   input  logic [1:0]      acc,
   input  logic [2:0]      mode,
   input  logic [1:0]      priv,
   input  logic            mprv,
   input  logic [1:0]      mpp,
   output logic [1:0]      eff_priv,
   output logic            bypass,
   output logic            bad,
   output logic            esz4,
   output logic [3:0]      idx_bits,
   output logic [5:0]      init_shift
);

   geom_t           g;
   int              top_bit;
   logic [VA_W-1:0] hi_sel;
   logic            canon;

   always_comb begin
      g        = mode_geom(mode);
      top_bit  = PG_SHIFT + int'(g.levels) * int'(g.idx_bits) - 1;
      eff_priv = (priv == PRIV_M && acc != ACC_FETCH && mprv) ? mpp : priv;
   end

   // one selector bit per address bit above the translated range
   for (genvar i = 0; i < VA_W; i++) begin : g_hi
      assign hi_sel[i] = (i >= top_bit);
   end

   always_comb begin
      canon      = ((vaddr & hi_sel) == '0) || ((vaddr & hi_sel) == hi_sel);
      bypass     = (eff_priv == PRIV_M) || g.bare;
      bad        = !bypass && (g.rsvd || !canon);
      esz4       = g.esz4;
      idx_bits   = g.idx_bits;
      init_shift = 6'((int'(g.levels) - 1) * int'(g.idx_bits));
   end

endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
   import ptw_pkg::*;
#(
   parameter int PPN_W = 44
) (
   input  logic [63:0]      pte,
   input  logic             esz4,
   input  logic [5:0]       shift,
   input  logic [1:0]       acc,
   input  logic [1:0]       eff_priv,
   input  logic             sum,
   input  logic             mxr,
   input  logic [PPN_W-1:0] vpn_lo,
   output logic             is_ptr,
   output logic             fault,
   output logic             need_upd,
   output logic [63:0]      new_pte,
   output logic [PPN_W-1:0] ppn,
   output logic [PPN_W-1:0] phys_ppn,
   output logic             perm_r,
   output logic             perm_w,
   output logic             perm_x
);

   logic             v, r, w, x, u, d, last, store;
   logic [PPN_W-1:0] low;

   always_comb begin
      v     = pte[BIT_V];
      r     = pte[BIT_R];
      w     = pte[BIT_W];
      x     = pte[BIT_X];
      u     = pte[BIT_U];
      d     = pte[BIT_D];
      last  = (shift == '0);
      store = (acc == ACC_STORE);
      ppn   = esz4 ? PPN_W'(pte[31:PPN_LSB]) : pte[PPN_LSB +: PPN_W];
      low   = ~({PPN_W{1'b1}} << shift);

      is_ptr = 1'b0;
      fault  = 1'b0;
      if (!v)                                                     fault = 1'b1;
      else if (!r && !w && !x) begin
         if (last) fault = 1'b1;
         else      is_ptr = 1'b1;
      end
      else if (w && !r)                                           fault = 1'b1;
      else if (u && eff_priv != PRIV_U && (!sum || acc == ACC_FETCH)) fault = 1'b1;
      else if (!u && eff_priv != PRIV_S)                          fault = 1'b1;
      else if ((ppn & low) != '0)                                 fault = 1'b1;
      else if (acc == ACC_LOAD && !(r || (x && mxr)))             fault = 1'b1;
      else if (store && !w)                                       fault = 1'b1;
      else if (acc == ACC_FETCH && !x)                            fault = 1'b1;

      new_pte        = pte;
      new_pte[BIT_A] = 1'b1;
      if (store) new_pte[BIT_D] = 1'b1;
      need_upd = (new_pte != pte);
      phys_ppn = ppn | (vpn_lo & low);
      perm_r   = r || (x && mxr);
      perm_w   = w && (store || d);
      perm_x   = x;
   end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W   = 64,
   parameter int PA_W   = 56,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [1:0]        req_acc,
   input  logic [2:0]        cfg_mode,
   input  logic [PA_W-13:0]  cfg_root_ppn,
   input  logic [1:0]        cfg_priv,
   input  logic              cfg_mprv,
   input  logic [1:0]        cfg_mpp,
   input  logic              cfg_sum,
   input  logic              cfg_mxr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   output logic              mem_req_we,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   output logic              res_valid,
   output logic              res_fault,
   output logic [PA_W-1:0]   res_paddr,
   output logic              res_r,
   output logic              res_w,
   output logic              res_x
);

   localparam int PPN_W = PA_W - PG_SHIFT;

   if (DATA_W != 64) begin : g_bad_data
      $error("ptw_walker: DATA_W must be 64");
   end
   if (PA_W < 34 || PA_W > 56) begin : g_bad_pa
      $error("ptw_walker: PA_W must lie in 34..56");
   end
   if (VA_W < PA_W || VA_W > 64) begin : g_bad_va
      $error("ptw_walker: VA_W must lie in PA_W..64");
   end

   typedef enum logic [3:0] {
      S_IDLE, S_START, S_RD_REQ, S_RD_WAIT, S_EVAL,
      S_CK_REQ, S_CK_WAIT, S_WR_REQ, S_WR_WAIT, S_DONE
   } st_e;

   st_e              st;
   logic [VA_W-1:0]  va_q;
   logic [1:0]       acc_q, priv_q, mpp_q;
   logic [2:0]       mode_q;
   logic             mprv_q, sum_q, mxr_q;
   logic [PPN_W-1:0] root_q;
   logic [PA_W-1:0]  base_q;
   logic [5:0]       shift_q;
   logic [63:0]      pte_q, upd_q;

   logic [1:0]       eff_priv;
   logic             bypass, bad, esz4;
   logic [3:0]       idx_bits;
   logic [5:0]       init_shift;

   logic             is_ptr, lf_fault, need_upd, p_r, p_w, p_x;
   logic [63:0]      new_pte, rsp_pte;
   logic [PPN_W-1:0] lf_ppn, phys_ppn;
   logic [9:0]       idx;
   logic [12:0]      off;
   logic [PA_W-1:0]  pte_addr;

   ptw_xlate_ctl #(.VA_W(VA_W)) u_ctl (
      .vaddr(va_q), .acc(acc_q), .mode(mode_q), .priv(priv_q),
      .mprv(mprv_q), .mpp(mpp_q), .eff_priv(eff_priv), .bypass(bypass),
      .bad(bad), .esz4(esz4), .idx_bits(idx_bits), .init_shift(init_shift)
   );

   ptw_leaf_eval #(.PPN_W(PPN_W)) u_leaf (
      .pte(pte_q), .esz4(esz4), .shift(shift_q), .acc(acc_q),
      .eff_priv(eff_priv), .sum(sum_q), .mxr(mxr_q),
      .vpn_lo(va_q[PG_SHIFT +: PPN_W]), .is_ptr(is_ptr), .fault(lf_fault),
      .need_upd(need_upd), .new_pte(new_pte), .ppn(lf_ppn),
      .phys_ppn(phys_ppn), .perm_r(p_r), .perm_w(p_w), .perm_x(p_x)
   );

   always_comb begin
      idx      = va_q[(PG_SHIFT + int'(shift_q)) +: 10] & {(idx_bits == 4'd10), 9'h1FF};
      off      = esz4 ? {1'b0, idx, 2'b00} : {idx, 3'b000};
      pte_addr = base_q + PA_W'(off);
      rsp_pte  = esz4 ? {32'h0, mem_rsp_rdata[31:0]} : mem_rsp_rdata;
   end

   assign req_ready     = (st == S_IDLE);
   assign res_valid     = (st == S_DONE);
   assign mem_req_valid = (st == S_RD_REQ) || (st == S_CK_REQ) || (st == S_WR_REQ);
   assign mem_req_we    = (st == S_WR_REQ);
   assign mem_req_addr  = pte_addr;
   assign mem_req_wdata = upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;
         va_q <= '0; acc_q <= '0; priv_q <= '0; mpp_q <= '0; mode_q <= '0;
         mprv_q <= 1'b0; sum_q <= 1'b0; mxr_q <= 1'b0; root_q <= '0;
         base_q <= '0; shift_q <= '0; pte_q <= '0; upd_q <= '0;
         res_fault <= 1'b0; res_paddr <= '0; res_r <= 1'b0; res_w <= 1'b0; res_x <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (req_valid) begin
               va_q <= req_vaddr; acc_q <= req_acc; priv_q <= cfg_priv;
               mpp_q <= cfg_mpp; mode_q <= cfg_mode; mprv_q <= cfg_mprv;
               sum_q <= cfg_sum; mxr_q <= cfg_mxr; root_q <= cfg_root_ppn;
               st <= S_START;
            end
            S_START: begin
               if (bypass) begin
                  res_fault <= 1'b0; res_paddr <= va_q[PA_W-1:0];
                  res_r <= 1'b1; res_w <= 1'b1; res_x <= 1'b1;
                  st <= S_DONE;
               end else if (bad) begin
                  res_fault <= 1'b1; res_paddr <= '0;
                  res_r <= 1'b0; res_w <= 1'b0; res_x <= 1'b0;
                  st <= S_DONE;
               end else begin
                  base_q  <= {root_q, 12'h0};
                  shift_q <= init_shift;
                  st      <= S_RD_REQ;
               end
            end
            S_RD_REQ:  if (mem_req_ready) st <= S_RD_WAIT;
            S_RD_WAIT: if (mem_rsp_valid) begin
               pte_q <= rsp_pte;
               st    <= S_EVAL;
            end
            S_EVAL: begin
               if (lf_fault) begin
                  res_fault <= 1'b1; res_paddr <= '0;
                  res_r <= 1'b0; res_w <= 1'b0; res_x <= 1'b0;
                  st <= S_DONE;
               end else if (is_ptr) begin
                  base_q  <= {lf_ppn, 12'h0};
                  shift_q <= shift_q - 6'(idx_bits);
                  st      <= S_RD_REQ;
               end else begin
                  res_fault <= 1'b0; res_paddr <= {phys_ppn, va_q[PG_SHIFT-1:0]};
                  res_r <= p_r; res_w <= p_w; res_x <= p_x;
                  upd_q <= new_pte;
                  st    <= need_upd ? S_CK_REQ : S_DONE;
               end
            end
            S_CK_REQ:  if (mem_req_ready) st <= S_CK_WAIT;
            S_CK_WAIT: if (mem_rsp_valid) begin
               if (rsp_pte != pte_q) begin
                  base_q  <= {root_q, 12'h0};
                  shift_q <= init_shift;
                  st      <= S_RD_REQ;
               end else begin
                  st <= S_WR_REQ;
               end
            end
            S_WR_REQ:  if (mem_req_ready) st <= S_WR_WAIT;
            S_WR_WAIT: if (mem_rsp_valid) st <= S_DONE;
            default:   st <= S_IDLE;
         endcase
      end
   end

   assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
   assert_res_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   assert_fault_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |-> !(res_r || res_w || res_x) && res_paddr == '0);
   assert_write_implies_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_fault && res_w |-> res_r);
   assert_wb_accessed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_A]);
   assert_wb_dirty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_we && acc_q == ACC_STORE |-> mem_req_wdata[BIT_D]);

endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic [2:0]  cfg_mode = '0;
   logic [43:0] cfg_root_ppn = '0;
   logic [1:0]  cfg_priv = '0;
   logic        cfg_mprv = 1'b0;
   logic [1:0]  cfg_mpp = '0;
   logic        cfg_sum = 1'b0;
   logic        cfg_mxr = 1'b0;
   logic        mem_req_valid, mem_req_we;
   logic        mem_req_ready;
   logic [55:0] mem_req_addr;
   logic [63:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_rdata = '0;
   logic        res_valid, res_fault, res_r, res_w, res_x;
   logic [55:0] res_paddr;

   always #2.5 clk = ~clk;

   ptw_walker u0 (.*);

   // memory model: 16 KB of 64-bit words, answers one cycle after acceptance
   logic [63:0] mem [0:2047];
   int          n_rd = 0, n_wr = 0;
   logic        stall_mode = 1'b0, stall_tog = 1'b0;
   logic        tamper_arm = 1'b0, tamper_seen = 1'b0;
   logic [55:0] tamper_addr = '0;
   assign mem_req_ready = !stall_mode || stall_tog;

   always @(posedge clk) begin
      logic [10:0] wi;
      logic [63:0] rd;
      stall_tog     <= ~stall_tog;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         wi = mem_req_addr[13:3];
         rd = '0;
         if (mem_req_we) begin
            if (cfg_mode == 3'd1) begin
               if (mem_req_addr[2]) mem[wi][63:32] = mem_req_wdata[31:0];
               else                 mem[wi][31:0]  = mem_req_wdata[31:0];
            end else mem[wi] = mem_req_wdata;
            n_wr = n_wr + 1;
         end else begin
            if (tamper_arm && mem_req_addr == tamper_addr) begin
               if (tamper_seen) begin
                  mem[wi]    = mem[wi] ^ 64'h100;
                  tamper_arm = 1'b0;
               end
               tamper_seen = 1'b1;
            end
            if (cfg_mode == 3'd1) rd = {32'h0, mem_req_addr[2] ? mem[wi][63:32] : mem[wi][31:0]};
            else                  rd = mem[wi];
            n_rd = n_rd + 1;
         end
         mem_rsp_valid <= 1'b1;
         mem_rsp_rdata <= rd;
      end
   end

   int          checks = 0, errors = 0;
   int          lat, rd0, wr0;
   logic [59:0] got;

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] m, input logic [43:0] root, input logic [1:0] pv,
                      input logic mp, input logic [1:0] pp, input logic sm, input logic mx);
      cfg_mode = m; cfg_root_ppn = root; cfg_priv = pv;
      cfg_mprv = mp; cfg_mpp = pp; cfg_sum = sm; cfg_mxr = mx;
   endtask

   // got = {fault, paddr, r, w, x}
   task automatic walk(input logic [63:0] va, input logic [1:0] acc);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc;
      rd0 = n_rd; wr0 = n_wr;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!res_valid && lat < 300) begin
         @(negedge clk);
         lat++;
      end
      if (!res_valid) begin
         checks++; errors++;
         $display("FAIL R13 watchdog: no result actual=%0d expected<300", lat);
      end
      got = {res_fault, res_paddr, res_r, res_w, res_x};
   endtask

   function automatic logic [59:0] ok_res(input logic [55:0] pa, input logic r, w, x);
      return {1'b0, pa, r, w, x};
   endfunction
   localparam logic [59:0] FAULT_RES = {1'b1, 59'h0};

   task automatic clear_mem();
      for (int i = 0; i < 2048; i++) mem[i] = '0;
   endtask

   localparam logic [63:0] SW_VA   = 64'h403123;
   localparam logic [43:0] LEAFPPN = 44'h12345;

   task automatic sweep_tables();
      clear_mem();
      mem[0]     = 64'h401;   // root entry 0 -> page 1
      mem[11'h202] = 64'h801; // page 1 entry 2 -> page 2
   endtask

   initial begin : watchdog
      #(5.0 * 190000);
      checks++; errors++;
      $display("FAIL R13 global watchdog actual=expired expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] pte, after;
      logic v, r, w, x, u, a, d, ef, upd, st;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13 reset outputs {ready,res_valid,mem_req_valid}",
          {61'h0, req_ready, res_valid, mem_req_valid}, 64'h4);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 bare mode
      cfg(3'd0, 44'h0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
      walk(64'h00AB_CDEF_1234_5678, 2'd2);
      chk("R2 bare result", 64'(got), 64'(ok_res(56'hAB_CDEF_1234_5678, 1, 1, 1)));
      chk("R2 bare latency", 64'(lat), 64'd2);
      chk("R2 bare reads", 64'(n_rd - rd0), 64'd0);

      // R2 machine bypass even with non-canonical address
      cfg(3'd2, 44'h0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
      walk(64'h8000_0000_0000_1000, 2'd1);
      chk("R2 machine bypass", 64'(got), 64'(ok_res(56'h00_0000_0000_1000, 1, 1, 1)));

      // R4 non-canonical and reserved mode
      cfg(3'd2, 44'h0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
      sweep_tables();
      walk(64'h40_0000_0000, 2'd1);
      chk("R4 non-canonical fault", 64'(got), 64'(FAULT_RES));
      chk("R4 non-canonical no reads", 64'(n_rd - rd0), 64'd0);
      chk("R4 fault latency", 64'(lat), 64'd2);
      walk(64'hFFFF_FFC0_0000_0000, 2'd1);
      chk("R4 sign-extended address walks (1 read)", 64'(n_rd - rd0), 64'd1);
      cfg(3'd7, 44'h0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
      walk(SW_VA, 2'd1);
      chk("R4 reserved mode fault", 64'(got), 64'(FAULT_RES));
      chk("R4 reserved mode no reads", 64'(n_rd - rd0), 64'd0);

      // R5 R6 R7 R9 R10 R12 exhaustive leaf sweep, three-level mode
      for (int f = 0; f < 128; f++) begin
         for (int acc = 0; acc < 3; acc++) begin
            for (int pv = 0; pv < 2; pv++) begin
               for (int sm = 0; sm < 2; sm++) begin
                  for (int mx = 0; mx < 2; mx++) begin
                     pte = ({20'h0, LEAFPPN} << 10) | 64'({f[6:5], 1'b0, f[4:0]});
                     mem[11'h403] = pte;
                     cfg(3'd2, 44'h0, 2'(pv), 1'b0, 2'd0, sm[0], mx[0]);
                     walk(SW_VA, 2'(acc));
                     v = f[0]; r = f[1]; w = f[2]; x = f[3]; u = f[4]; a = f[5]; d = f[6];
                     st = (acc == 2);
                     ef = !v || (!r && !w && !x) || (w && !r) ||
                          (u && pv != 0 && (sm == 0 || acc == 0)) || (!u && pv != 1) ||
                          (acc == 1 && !(r || (x && mx == 1))) || (st && !w) || (acc == 0 && !x);
                     upd   = !ef && (!a || (st && !d));
                     after = upd ? (pte | 64'h40 | (st ? 64'h80 : 64'h0)) : pte;
                     if (ef) chk($sformatf("R5 R6 R7 R9 fault f=%0h acc=%0d pv=%0d", f, acc, pv),
                                 64'(got), 64'(FAULT_RES));
                     else    chk($sformatf("R9 R12 result f=%0h acc=%0d pv=%0d", f, acc, pv),
                                 64'(got), 64'(ok_res({LEAFPPN, 12'h123}, r || (x && mx == 1),
                                                      w && (st || d), x)));
                     chk($sformatf("R10 stored entry f=%0h acc=%0d", f, acc), mem[11'h403], after);
                     chk($sformatf("R10 traffic f=%0h acc=%0d", f, acc),
                         64'({16'(n_rd - rd0), 16'(n_wr - wr0)}), 64'({16'(3 + upd), 16'(upd)}));
                  end
               end
            end
         end
      end

      // R13 exact walk latencies
      mem[11'h403] = ({20'h0, LEAFPPN} << 10) | 64'hCF;
      cfg(3'd2, 44'h0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
      walk(SW_VA, 2'd1);
      chk("R13 three-level latency, no write-back", 64'(lat), 64'd11);
      mem[11'h403] = ({20'h0, LEAFPPN} << 10) | 64'h0F;
      walk(SW_VA, 2'd2);
      chk("R13 three-level latency with write-back", 64'(lat), 64'd15);

      // R13 stalled memory port
      mem[11'h403] = ({20'h0, LEAFPPN} << 10) | 64'h0F;
      stall_mode = 1'b1;
      walk(SW_VA, 2'd2);
      stall_mode = 1'b0;
      chk("R13 stalled port result", 64'(got), 64'(ok_res({LEAFPPN, 12'h123}, 1, 1, 1)));
      chk("R13 stalled port entry", mem[11'h403], ({20'h0, LEAFPPN} << 10) | 64'hCF);

      // R3 modify-privilege
      mem[11'h403] = ({20'h0, LEAFPPN} << 10) | 64'hDF; // user page, all set
      cfg(3'd2, 44'h0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0);
      walk(SW_VA, 2'd1);
      chk("R3 load uses previous privilege U", 64'(got), 64'(ok_res({LEAFPPN, 12'h123}, 1, 1, 1)));
      cfg(3'd2, 44'h0, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0);
      walk(SW_VA, 2'd2);
      chk("R3 store as S on user page faults", 64'(got), 64'(FAULT_RES));
      cfg(3'd2, 44'h0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0);
      walk(64'h8000_0000_0000_2000, 2'd0);
      chk("R3 fetch ignores modify-privilege", 64'(got), 64'(ok_res(56'h2000, 1, 1, 1)));

      // R8 superpage at level 1 (aligned and misaligned)
      mem[11'h202] = (64'h400 << 10) | 64'hCF;
      cfg(3'd2, 44'h0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
      walk(SW_VA, 2'd1);
      chk("R8 superpage merge", 64'(got), 64'(ok_res(56'h403123, 1, 1, 1)));
      mem[11'h202] = (64'h401 << 10) | 64'hCF;
      walk(SW_VA, 2'd1);
      chk("R8 misaligned superpage", 64'(got), 64'(FAULT_RES));

      // R11 entry changes between read and re-check
      sweep_tables();
      mem[11'h403] = ({20'h0, LEAFPPN} << 10) | 64'h0F;
      tamper_addr = 56'h2018; tamper_seen = 1'b0; tamper_arm = 1'b1;
      walk(SW_VA, 2'd2);
      chk("R11 restart traffic {reads,writes}", 64'({16'(n_rd - rd0), 16'(n_wr - wr0)}),
          64'({16'd8, 16'd1}));
      chk("R11 final entry", mem[11'h403], (({20'h0, LEAFPPN} << 10) | 64'h0F) ^ 64'h100 | 64'hC0);
      chk("R11 result", 64'(got), 64'(ok_res({LEAFPPN, 12'h123}, 1, 1, 1)));

      // R1 two-level, 4-byte entries, root page 3
      clear_mem();
      mem[11'h600] = {32'h0000_0C01, 32'h0};      // 0x3004 -> page 3
      mem[11'h602] = {32'h000A_AC0F, 32'h0};      // 0x3014 leaf, A/D clear
      cfg(3'd1, 44'h3, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
      walk(64'h0040_5045, 2'd2);
      chk("R1 two-level result", 64'(got), 64'(ok_res(56'h2AB045, 1, 1, 1)));
      chk("R1 two-level 4-byte write-back", mem[11'h602], {32'h000A_ACCF, 32'h0});
      chk("R1 two-level traffic", 64'({16'(n_rd - rd0), 16'(n_wr - wr0)}), 64'({16'd3, 16'd1}));

      // R1 R8 four-level, leaf at root (shift 27)
      clear_mem();
      mem[11'h207] = (64'h1 << 37) | 64'hCF;
      cfg(3'd3, 44'h1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
      walk((64'd7 << 39) | 64'h123_4567, 2'd1);
      chk("R1 four-level root leaf", 64'(got), 64'(ok_res((56'h1 << 39) | 56'h123_4567, 1, 1, 1)));
      chk("R1 four-level reads", 64'(n_rd - rd0), 64'd1);
      mem[11'h207] = (64'h1 << 37) | (64'h1 << 10) | 64'hCF;
      walk((64'd7 << 39) | 64'h123_4567, 2'd1);
      chk("R8 four-level misaligned", 64'(got), 64'(FAULT_RES));

      // R1 five-level, leaf at root (shift 36)
      mem[11'h403] = (64'h1 << 46) | 64'hCF;
      cfg(3'd4, 44'h2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
      walk((64'd3 << 48) | 64'hABC, 2'd1);
      chk("R1 five-level root leaf", 64'(got), 64'(ok_res((56'h1 << 48) | 56'hABC, 1, 1, 1)));

      // R5 pointer chain ends at invalid entry in five-level mode
      mem[11'h403] = 64'h801;
      walk((64'd3 << 48) | 64'hABC, 2'd1);
      chk("R5 invalid next-level entry", 64'(got), 64'(FAULT_RES));
      chk("R5 invalid walk reads", 64'(n_rd - rd0), 64'd2);

      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule